// File: doc/BRIEF.md
# Double-Buffered Parallel Channel Output Controller

This block is the logic-side controller of an isolated multi-channel switch. It samples a parallel word of channel commands through two active-low strobes, a capture strobe and a commit strobe, and holds them in two stages: a capture buffer and a send buffer. Channel states leave the block as one-cycle frame requests that carry a full data word. An isolated-side model receives each frame after a fixed link latency and writes it into the channel output register. A master enable forces every channel off at once.

The strobes can be used in two ways. When they are tied together, pulling both low makes the channels follow the command inputs directly. When they are driven separately, software first captures a word and then commits it with the commit strobe held low. On the commit strobe's rising edge, all channels switch together. This lets several controllers share one commit line. While the link is idle, a periodic refresh re-sends the send buffer. The refresh is suppressed while a commit is being held low, so that the link is quiet by the time the commit edge arrives.

Top module: `dbuf_chan_ctl`

## Requirements
- R1: After reset, both buffers and all channel outputs are 0, so a refresh straight after reset keeps every channel off.
- R2: In the cycle after `out_en_i` is sampled low, every bit of `chan_o` is 0. It stays 0 for as long as `out_en_i` is low, whatever the strobes and frames do.
- R3: With `cap_n_i` and `commit_n_i` both high, neither buffer changes and `chan_o` keeps its value, whatever `cmd_i` does.
- R4: With `cap_n_i` low and `commit_n_i` high, the capture buffer takes `cmd_i` on each clock and `chan_o` does not change.
- R5: With `cap_n_i` high and `commit_n_i` low, the send buffer takes the capture buffer. No new frame is started, except one already owed to an earlier commit edge, and `chan_o` does not change.
- R6: A rising edge of `commit_n_i` while `cap_n_i` is high sends the current send buffer. `chan_o` shows it no more than LINK_LAT+2 cycles after the edge is sampled, provided the link is idle.
- R7: With both strobes low, frames carry `cmd_i` directly, so `chan_o` follows `cmd_i` with only the link delay.
- R8: With no commit held low, a refresh frame carrying the send buffer is issued once REFRESH_CYC idle cycles have passed after the previous frame completed. The gap between consecutive refresh requests is therefore constant: REFRESH_CYC+LINK_LAT+2 cycles.
- R9: `frame_req_o` is a one-cycle pulse, and no new frame starts until `frame_done_o` has reported the previous one. Two requests are never back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | CHANNELS | Per-channel on/off commands |
| cap_n_i | input | 1 | Capture strobe, active low |
| commit_n_i | input | 1 | Commit strobe, active low; its rising edge applies the send buffer |
| out_en_i | input | 1 | Master enable; low forces all channels off |
| frame_req_o | output | 1 | One-cycle frame request toward the isolated side |
| frame_data_o | output | CHANNELS | Data word carried by the frame |
| frame_done_o | output | 1 | One-cycle pulse when the isolated side has applied a frame |
| chan_o | output | CHANNELS | Channel output register on the isolated side |

## Verification
The bench builds the block with CHANNELS=4, REFRESH_CYC=16 and LINK_LAT=2. This makes every one of the sixteen command words reachable, both through the capture–commit–edge path and through the tied-strobe path. The short refresh period lets the bench see several refresh frames within a single test, so it can measure the exact gap between them. It can also confirm that no frame starts while a commit is held low, and that a refresh restores the channels once the master enable returns.

// File: rtl/dbuf_chan_pkg.sv
package dbuf_chan_pkg;
   typedef enum logic [1:0] {
      STB_IDLE    = 2'd0,
      STB_CAPTURE = 2'd1,
      STB_COMMIT  = 2'd2,
      STB_DIRECT  = 2'd3
   } strobe_mode_e;

   typedef enum logic [1:0] {
      SRC_NONE    = 2'd0,
      SRC_APPLY   = 2'd1,
      SRC_DIRECT  = 2'd2,
      SRC_REFRESH = 2'd3
   } frame_src_e;
endpackage

// File: rtl/dbuf_strobe_decode.sv
module dbuf_strobe_decode
   import dbuf_chan_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap_n,
   input  logic         commit_n,
   output strobe_mode_e mode,
   output logic         apply_edge
);
   logic commit_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) commit_prev_q <= 1'b1;
      else        commit_prev_q <= commit_n;
   end

   always_comb begin
      unique case ({cap_n, commit_n})
         2'b11:   mode = STB_IDLE;
         2'b01:   mode = STB_CAPTURE;
         2'b10:   mode = STB_COMMIT;
         default: mode = STB_DIRECT;
      endcase
   end

   // rising commit edge counts only when the capture strobe is released
   assign apply_edge = commit_n && !commit_prev_q && cap_n;
endmodule

// File: rtl/dbuf_refresh_timer.sv
module dbuf_refresh_timer #(
   parameter int unsigned REFRESH_CYC = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic run,
   input  logic suppress,
   output logic due
);
   localparam int unsigned CW = (REFRESH_CYC < 2) ? 1 : $clog2(REFRESH_CYC);
   localparam logic [CW-1:0] LIMIT = CW'(REFRESH_CYC - 1);

   initial begin
      if (REFRESH_CYC < 2) $error("REFRESH_CYC must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (restart)                 cnt_q <= '0;
      else if (run && cnt_q != LIMIT)   cnt_q <= cnt_q + 1'b1;
   end

   assign due = (cnt_q == LIMIT) && !suppress;

   always_ff @(posedge clk) begin
      if (rst_n) begin
         assert_cnt_bound_R8: assert (cnt_q <= LIMIT)
            else $error("refresh counter beyond limit");
      end
   end
endmodule

// File: rtl/dbuf_link_model.sv
module dbuf_link_model #(
   parameter int unsigned CHANNELS = 8,
   parameter int unsigned LINK_LAT = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req,
   input  logic [CHANNELS-1:0] data,
   input  logic                out_en,
   output logic                done,
   output logic [CHANNELS-1:0] chan
);
   localparam int unsigned LW = (LINK_LAT < 2) ? 1 : $clog2(LINK_LAT);

   initial begin
      if (LINK_LAT < 1) $error("LINK_LAT must be at least 1");
   end

   logic                act_q;
   logic [LW-1:0]       cnt_q;
   logic [CHANNELS-1:0] hold_q;
   logic                finish;

   assign finish = act_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         cnt_q  <= '0;
         hold_q <= '0;
         done   <= 1'b0;
      end else begin
         done <= finish;
         if (req) begin
            act_q  <= 1'b1;
            cnt_q  <= LW'(LINK_LAT - 1);
            hold_q <= data;
         end else if (finish) begin
            act_q <= 1'b0;
         end else if (act_q) begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   for (genvar b = 0; b < CHANNELS; b++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       chan[b] <= 1'b0;
         else if (!out_en) chan[b] <= 1'b0;
         else if (finish)  chan[b] <= hold_q[b];
      end
   end

   assert_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> (chan == '0))
      else $error("channels not off after enable dropped");

   assert_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!act_q && out_en) |=> $stable(chan))
      else $error("channels changed with no frame in flight");
endmodule

// File: rtl/dbuf_chan_ctl.sv
module dbuf_chan_ctl
   import dbuf_chan_pkg::*;
#(
   parameter int unsigned CHANNELS    = 8,
   parameter int unsigned REFRESH_CYC = 6667,
   parameter int unsigned LINK_LAT    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [CHANNELS-1:0] cmd_i,
   input  logic                cap_n_i,
   input  logic                commit_n_i,
   input  logic                out_en_i,
   output logic                frame_req_o,
   output logic [CHANNELS-1:0] frame_data_o,
   output logic                frame_done_o,
   output logic [CHANNELS-1:0] chan_o
);
   initial begin
      if (CHANNELS < 1) $error("CHANNELS must be at least 1");
   end

   strobe_mode_e        mode;
   logic                apply_edge;
   logic [CHANNELS-1:0] ibuf_q, tbuf_q;
   logic                busy_q, apply_pend_q;
   logic                apply_want, refresh_due;
   frame_src_e          grant;
   logic [CHANNELS-1:0] grant_data;

   dbuf_strobe_decode i_decode (
      .clk        (clk),
      .rst_n      (rst_n),
      .cap_n      (cap_n_i),
      .commit_n   (commit_n_i),
      .mode       (mode),
      .apply_edge (apply_edge)
   );

   dbuf_refresh_timer #(.REFRESH_CYC(REFRESH_CYC)) i_refresh (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (frame_done_o),
      .run      (!busy_q),
      .suppress (mode == STB_COMMIT),
      .due      (refresh_due)
   );

   // two-stage buffering
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibuf_q <= '0;
         tbuf_q <= '0;
      end else begin
         unique case (mode)
            STB_CAPTURE: ibuf_q <= cmd_i;
            STB_COMMIT:  tbuf_q <= ibuf_q;
            STB_DIRECT: begin
               ibuf_q <= cmd_i;
               tbuf_q <= cmd_i;
            end
            default: ;
         endcase
      end
   end

   // frame source arbitration: commit edge, then direct, then refresh
   assign apply_want = apply_pend_q || apply_edge;

   always_comb begin
      grant      = SRC_NONE;
      grant_data = tbuf_q;
      if (!busy_q) begin
         if (apply_want) begin
            grant = SRC_APPLY;
         end else if (mode == STB_DIRECT) begin
            grant      = SRC_DIRECT;
            grant_data = cmd_i;
         end else if (refresh_due) begin
            grant = SRC_REFRESH;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         apply_pend_q <= 1'b0;
         frame_req_o  <= 1'b0;
         frame_data_o <= '0;
      end else begin
         apply_pend_q <= apply_want && (grant != SRC_APPLY);
         frame_req_o  <= (grant != SRC_NONE);
         if (grant != SRC_NONE) begin
            frame_data_o <= grant_data;
            busy_q       <= 1'b1;
         end else if (frame_done_o) begin
            busy_q <= 1'b0;
         end
      end
   end

   dbuf_link_model #(.CHANNELS(CHANNELS), .LINK_LAT(LINK_LAT)) i_link (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (frame_req_o),
      .data   (frame_data_o),
      .out_en (out_en_i),
      .done   (frame_done_o),
      .chan   (chan_o)
   );

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_n_i && commit_n_i) |=> ($stable(ibuf_q) && $stable(tbuf_q)))
      else $error("buffers moved with both strobes high");

   assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_n_i && commit_n_i) |=> (ibuf_q == $past(cmd_i)))
      else $error("capture buffer missed the command word");

   assert_no_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_n_i && !commit_n_i && !apply_pend_q) |=> !frame_req_o)
      else $error("frame started while commit held low");

   assert_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_req_o |=> !frame_req_o)
      else $error("back-to-back frame requests");

   assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done_o |-> busy_q)
      else $error("completion with no outstanding frame");
endmodule

// File: tb/test_dbuf_chan_ctl.sv
module test_dbuf_chan_ctl;
   localparam int W   = 4;
   localparam int REF = 16;
   localparam int LAT = 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] cmd = '0;
   logic         cap_n = 1'b1, commit_n = 1'b1, out_en = 1'b1;
   logic         frame_req, frame_done;
   logic [W-1:0] frame_data, chan;

   int checks = 0, fails = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   dbuf_chan_ctl #(.CHANNELS(W), .REFRESH_CYC(REF), .LINK_LAT(LAT)) i_dbuf_chan_ctl (
      .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .cap_n_i(cap_n), .commit_n_i(commit_n),
      .out_en_i(out_en), .frame_req_o(frame_req), .frame_data_o(frame_data),
      .frame_done_o(frame_done), .chan_o(chan)
   );

   task automatic tick(input int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run;
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   // capture, commit, then release the commit strobe
   task automatic scm_update(input logic [W-1:0] val, input logic [W-1:0] prev);
      cmd = val; cap_n = 1'b0;
      tick(2);
      cap_n = 1'b1;
      check("R4 outputs held during capture", chan, prev);
      commit_n = 1'b0;
      tick(12);
      check("R5 outputs held during commit", chan, prev);
      commit_n = 1'b1;
      tick(LAT + 6);
      check("R6 outputs after commit edge", chan, val);
   endtask

   initial begin
      int unsigned t0;
      t0 = 0;
      while (t0 < 20000 && !finished) begin
         @(posedge clk);
         t0++;
      end
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", t0, 0);
         finish_run();
      end
   end

   initial begin
      logic [W-1:0] prev;
      int n, stamps[3];
      logic last;

      tick(3);
      check("R1 reset outputs", chan, 0);
      rst_n = 1'b1;
      tick(40);
      check("R1 refresh after reset keeps off", chan, 0);

      // exhaustive sweep through capture/commit path
      prev = '0;
      for (int p = 0; p < (1 << W); p++) begin
         scm_update(W'(p), prev);
         prev = W'(p);
      end

      // R5: no frames while commit held low
      commit_n = 1'b0;
      tick(5);
      n = 0;
      for (int i = 0; i < 60; i++) begin
         tick();
         if (frame_req) n++;
      end
      check("R5 frames while commit low", n, 0);
      commit_n = 1'b1;
      tick(10);

      // R8: refresh gap
      n = 0;
      for (int i = 0; i < 120 && n < 3; i++) begin
         tick();
         if (frame_req) begin
            stamps[n] = i;
            n++;
         end
      end
      check("R8 refresh requests seen", n, 3);
      check("R8 refresh gap", stamps[1] - stamps[0], REF + LAT + 2);
      check("R8 refresh gap constant", stamps[2] - stamps[1], stamps[1] - stamps[0]);
      check("R8 refresh carries send buffer", frame_data, prev);

      // R3: command changes ignored with both strobes high
      cmd = ~prev;
      tick(50);
      check("R3 outputs unchanged", chan, prev);
      commit_n = 1'b0;
      tick(12);
      commit_n = 1'b1;
      tick(LAT + 6);
      check("R3 capture buffer untouched", chan, prev);

      // R2: master enable
      out_en = 1'b0;
      tick(1);
      check("R2 off next cycle", chan, 0);
      tick(45);
      check("R2 off while low", chan, 0);
      out_en = 1'b1;
      tick(REF + LAT + 8);
      check("R8 refresh restores channels", chan, prev);

      // R7: direct mode sweep
      cap_n = 1'b0; commit_n = 1'b0;
      for (int p = 0; p < (1 << W); p++) begin
         cmd = W'(p);
         tick(12);
         check("R7 direct follow", chan, p);
      end

      // R9: spacing of requests under continuous direct traffic
      n = 0; last = 1'b0;
      for (int i = 0; i < 40; i++) begin
         tick();
         if (frame_req && last) n++;
         last = frame_req;
      end
      check("R9 back-to-back requests", n, 0);
      check("R9 single-cycle pulse", frame_req && last, 0);

      finish_run();
   end
endmodule